// File: doc/BRIEF.md
# Sampling converter conversion-control interface

This block is the digital control side of a 12-bit sampling converter whose result is read over a byte-wide parallel bus. An active-low chip select and a read/convert strobe are combined by a logical OR. A falling edge of that combined strobe, which means both inputs are now low, starts a conversion. The chip select and read/convert inputs may reach that state in either order. The other control state, chip select low with read/convert high, opens the output bus.

There is no analog path. A sample-data input is captured at the hold instant, and a cycle counter stands in for conversion time. The busy output is low while a conversion runs. It rises in the same cycle that the captured sample is written into the output register, so its rising edge marks valid data. After each conversion, an acquisition window of programmable length must pass before the next start is accepted. A power-down input blocks new conversions and keeps the last result.

The 12-bit two's complement result is read as two bytes, chosen by a byte-select input. The 8 most significant bits form one byte. The 4 least significant bits form the other byte, placed in its upper nibble. All control inputs pass through two-flop synchronisers before any edge is detected. The bus tri-state is represented by an enable output, and the data lines read zero whenever that enable is low.

Top module: `adc_ctrl_if`

## Requirements
- R1: Reset state:
  - busy_o is 1 and data_oe_o is 0.
  - The output register is zero, so a read before any conversion returns 0x00 for both bytes.
- R2: With cs_ni low, a falling edge on rc_i starts a conversion.
- R3: With rc_i low, a falling edge on cs_ni starts a conversion.
- R4: Conversion timing and result:
  - busy_o stays low for exactly CONV_CYC clock cycles after a start.
  - On its rise, the output register holds sample_i as it was at the start.
  - The value is carried bit for bit as a two's complement code.
- R5: A start request that arrives while busy_o is low has no effect. It does not stretch or restart the conversion, it does not recapture sample_i, and it is not queued.
- R6: data_oe_o is 1 only while par_en_i is 1, cs_ni is low and rc_i is high. While data_oe_o is 0, data_o reads 0x00.
- R7: Byte selection:
  - With byte_sel_i = 0, data_o shows result bits [11:4].
  - With byte_sel_i = 1, data_o shows {result[3:0], 4'b0000}.
  - Changing byte_sel_i while the bus is enabled changes data_o without a new read edge.
- R8: While pwrdn_i is 1, start requests are ignored and the output register keeps its previous value.
- R9: A start request that arrives within ACQ_CYC cycles after busy_o rises is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| rc_i | input | 1 | Read/convert strobe: fall converts, high reads |
| byte_sel_i | input | 1 | 0 selects the MSB byte, 1 selects the LSB nibble byte |
| par_en_i | input | 1 | Parallel output mode select |
| pwrdn_i | input | 1 | Power-down; blocks conversions |
| sample_i | input | 12 | Stand-in for the analog sample, captured at hold |
| busy_o | output | 1 | Low while a conversion runs |
| data_oe_o | output | 1 | Bus drive enable (bus high-impedance when 0) |
| data_o | output | 8 | Parallel data byte |

## Verification
Most internal faults reach the ports within one conversion.
- A conversion counter that is off by one changes how many cycles busy_o stays low, which is visible by the end of that conversion.
- A hold register loaded at the wrong instant shows as a wrong byte at the first read after the conversion ends.
- A lost acquisition or power-down interlock shows as busy_o falling when it should not, three to four cycles after the offending strobe edge.
- A wrong enable or byte mux shows on data_o within the two synchroniser cycles that follow the change of chip select, read/convert or byte select.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;
  // bit order of the synchronised control vector
  localparam int unsigned CTL_W    = 5;
  localparam int unsigned CTL_CS   = 0;
  localparam int unsigned CTL_RC   = 1;
  localparam int unsigned CTL_BSEL = 2;
  localparam int unsigned CTL_PAR  = 3;
  localparam int unsigned CTL_PWR  = 4;
  // idle levels: chip select and read/convert rest high
  localparam logic [CTL_W-1:0] CTL_RST = 5'b00011;
endpackage

// File: rtl/adc_ctl_sync.sv
module adc_ctl_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= RST_VAL[g];
        s2_q <= RST_VAL[g];
      end else begin
        s1_q <= d_i[g];
        s2_q <= s1_q;
      end
    end
    assign q_o[g] = s2_q;
  end
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq #(
  parameter int unsigned SW       = 12,
  parameter int unsigned CONV_CYC = 20,
  parameter int unsigned ACQ_CYC  = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_req_i,
  input  logic          pwr_i,
  input  logic [SW-1:0] sample_i,
  output logic          busy_o,
  output logic          acq_done_o,
  output logic [SW-1:0] result_o
);
  localparam int unsigned CNT_W = $clog2(CONV_CYC + 1);
  localparam int unsigned ACQ_W = $clog2(ACQ_CYC + 1);

  logic [CNT_W-1:0] conv_cnt_q;
  logic [ACQ_W-1:0] acq_cnt_q;
  logic [SW-1:0]    hold_q;
  logic [SW-1:0]    result_q;
  logic             busy_q;

  assign acq_done_o = (acq_cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b1;
      conv_cnt_q <= '0;
      acq_cnt_q  <= '0;
      hold_q     <= '0;
      result_q   <= '0;
    end else if (busy_q) begin
      if (!acq_done_o) acq_cnt_q <= acq_cnt_q - 1'b1;
      // accept only when idle, acquired and powered
      if (start_req_i && acq_done_o && !pwr_i) begin
        busy_q     <= 1'b0;
        hold_q     <= sample_i;
        conv_cnt_q <= CNT_W'(CONV_CYC - 1);
      end
    end else if (conv_cnt_q == '0) begin
      busy_q    <= 1'b1;
      result_q  <= hold_q;
      acq_cnt_q <= ACQ_W'(ACQ_CYC);
    end else begin
      conv_cnt_q <= conv_cnt_q - 1'b1;
    end
  end

  assign busy_o   = busy_q;
  assign result_o = result_q;
endmodule

// File: rtl/adc_byte_mux.sv
module adc_byte_mux #(
  parameter int unsigned SW = 12,
  parameter int unsigned BW = 8
) (
  input  logic [SW-1:0] result_i,
  input  logic          bsel_i,
  input  logic          oe_i,
  output logic [BW-1:0] data_o
);
  localparam int unsigned LO_W  = SW - BW;
  localparam int unsigned PAD_W = BW - LO_W;

  logic [BW-1:0] hi_byte, lo_byte;

  assign hi_byte = result_i[SW-1 -: BW];
  assign lo_byte = {result_i[LO_W-1:0], {PAD_W{1'b0}}};

  always_comb begin
    if (!oe_i)       data_o = '0;
    else if (bsel_i) data_o = lo_byte;
    else             data_o = hi_byte;
  end
endmodule

// File: rtl/adc_ctrl_if.sv
module adc_ctrl_if
  import adc_ctrl_pkg::*;
#(
  parameter int unsigned SW       = 12,
  parameter int unsigned BW       = 8,
  parameter int unsigned CONV_CYC = 20,
  parameter int unsigned ACQ_CYC  = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_ni,
  input  logic          rc_i,
  input  logic          byte_sel_i,
  input  logic          par_en_i,
  input  logic          pwrdn_i,
  input  logic [SW-1:0] sample_i,
  output logic          busy_o,
  output logic          data_oe_o,
  output logic [BW-1:0] data_o
);
  logic [CTL_W-1:0] ctl_raw, ctl_s;
  logic             cs_s, rc_s, bsel_s, par_s, pwr_s;
  logic             strobe, strobe_q, start_req, acq_done;
  logic [SW-1:0]    result_q;

  assign ctl_raw = {pwrdn_i, par_en_i, byte_sel_i, rc_i, cs_ni};

  adc_ctl_sync #(.W(CTL_W), .RST_VAL(CTL_RST)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ctl_raw),
    .q_o   (ctl_s)
  );

  assign cs_s   = ctl_s[CTL_CS];
  assign rc_s   = ctl_s[CTL_RC];
  assign bsel_s = ctl_s[CTL_BSEL];
  assign par_s  = ctl_s[CTL_PAR];
  assign pwr_s  = ctl_s[CTL_PWR];

  // OR of chip select and read/convert: its fall is a convert request
  assign strobe = cs_s | rc_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) strobe_q <= 1'b1;
    else         strobe_q <= strobe;
  end

  assign start_req = strobe_q & ~strobe;
  assign data_oe_o = par_s & ~cs_s & rc_s;

  adc_conv_seq #(.SW(SW), .CONV_CYC(CONV_CYC), .ACQ_CYC(ACQ_CYC)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_req_i(start_req),
    .pwr_i      (pwr_s),
    .sample_i   (sample_i),
    .busy_o     (busy_o),
    .acq_done_o (acq_done),
    .result_o   (result_q)
  );

  adc_byte_mux #(.SW(SW), .BW(BW)) u_mux (
    .result_i(result_q),
    .bsel_i  (bsel_s),
    .oe_i    (data_oe_o),
    .data_o  (data_o)
  );
endmodule

// File: rtl/adc_ctrl_chk.sv
module adc_ctrl_chk #(
  parameter int unsigned SW       = 12,
  parameter int unsigned BW       = 8,
  parameter int unsigned CONV_CYC = 20
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          busy_o,
  input logic          data_oe_o,
  input logic [BW-1:0] data_o,
  input logic          bsel_s,
  input logic          pwr_s,
  input logic          acq_done,
  input logic [SW-1:0] result
);
  localparam int unsigned LW    = $clog2(CONV_CYC + 2);
  localparam int unsigned PAD_W = BW - (SW - BW);

  logic [LW-1:0] low_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     low_cnt <= '0;
    else if (busy_o) low_cnt <= '0;
    else             low_cnt <= low_cnt + 1'b1;
  end

  assert_busy_len_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> low_cnt == LW'(CONV_CYC));

  // R5: a request during conversion must not stretch it
  assert_no_restart_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    low_cnt <= LW'(CONV_CYC));

  assert_result_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$rose(busy_o) |-> $stable(result));

  assert_bus_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_oe_o |-> data_o == '0);

  assert_lsb_pad_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_oe_o && bsel_s) |-> data_o[PAD_W-1:0] == '0);

  assert_pwr_block_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(!pwr_s));

  assert_acq_gap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(acq_done));
endmodule

bind adc_ctrl_if adc_ctrl_chk #(.SW(SW), .BW(BW), .CONV_CYC(CONV_CYC)) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .busy_o   (busy_o),
  .data_oe_o(data_oe_o),
  .data_o   (data_o),
  .bsel_s   (bsel_s),
  .pwr_s    (pwr_s),
  .acq_done (acq_done),
  .result   (result_q)
);

// File: tb/test_adc_ctrl_if.sv
`timescale 1ns/1ps
module test_adc_ctrl_if;
  localparam int CONV = 20;
  localparam int ACQ  = 5;
  localparam int NV   = 6;
  // {sample, msb byte, lsb byte}
  localparam logic [27:0] VEC [NV] = '{
    {12'h7FF, 8'h7F, 8'hF0},
    {12'h800, 8'h80, 8'h00},
    {12'hFFF, 8'hFF, 8'hF0},
    {12'h000, 8'h00, 8'h00},
    {12'hA5C, 8'hA5, 8'hC0},
    {12'h123, 8'h12, 8'h30}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, rc = 1'b1, bsel = 1'b0, par = 1'b1, pwr = 1'b0;
  logic [11:0] smp = '0;
  logic busy, oe;
  logic [7:0] data;
  int n_chk = 0, n_err = 0;

  always #2.5 clk = ~clk;

  adc_ctrl_if #(.CONV_CYC(CONV), .ACQ_CYC(ACQ)) i_adc_ctrl_if (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .rc_i(rc),
    .byte_sel_i(bsel), .par_en_i(par), .pwrdn_i(pwr),
    .sample_i(smp), .busy_o(busy), .data_oe_o(oe), .data_o(data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busy_len(output int len);
    int k = 0;
    len = 0;
    while (busy && k < 12) begin tick(1); k++; end
    while (!busy && len < 1000) begin len++; tick(1); end
  endtask

  task automatic start(input int via_cs, input logic [11:0] s);
    smp = s;
    if (via_cs == 0) begin cs_n = 1'b0; tick(3); rc = 1'b0; end
    else             begin rc = 1'b0; tick(3); cs_n = 1'b0; end
  endtask

  task automatic read(output logic [7:0] hi, output logic [7:0] lo);
    cs_n = 1'b0; rc = 1'b1; tick(4);
    bsel = 1'b0; tick(3); hi = data;
    bsel = 1'b1; tick(3); lo = data;
    bsel = 1'b0; cs_n = 1'b1; tick(3);
  endtask

  initial begin
    #1000000;
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int len;
    logic [7:0] hi, lo;
    tick(3);
    chk("R1 busy in reset", busy, 1);
    chk("R1 oe in reset", oe, 0);
    chk("R1 data in reset", data, 0);
    rst_n = 1'b1; tick(3);
    read(hi, lo);
    chk("R1 msb before conversion", hi, 8'h00);
    chk("R1 lsb before conversion", lo, 8'h00);

    for (int i = 0; i < NV; i++) begin
      start(i % 2, VEC[i][27:16]);
      busy_len(len);
      chk((i % 2) ? "R3 cs-fall start len" : "R2 rc-fall start len", len, CONV);
      tick(ACQ + 2);
      read(hi, lo);
      chk("R4 R7 msb byte", hi, VEC[i][15:8]);
      chk("R7 lsb byte", lo, VEC[i][7:0]);
    end

    // R5: extra start request while converting
    start(0, 12'h3C1);
    while (busy) tick(1);
    len = 0;
    while (!busy && len < 1000) begin
      len++;
      if (len == 3) begin smp = 12'h5A5; rc = 1'b1; end
      if (len == 6) rc = 1'b0;
      tick(1);
    end
    chk("R5 len with request during busy", len, CONV);
    tick(ACQ + 2);
    read(hi, lo);
    chk("R5 msb not recaptured", hi, 8'h3C);
    chk("R5 lsb not recaptured", lo, 8'h10);

    // R9: request right after busy rises
    start(0, 12'h111);
    busy_len(len);
    rc = 1'b1; tick(1); rc = 1'b0; smp = 12'h222;
    len = 0;
    for (int k = 0; k < 12; k++) begin if (!busy) len++; tick(1); end
    chk("R9 no start in acquisition", len, 0);
    read(hi, lo);
    chk("R9 msb kept", hi, 8'h11);
    chk("R9 lsb kept", lo, 8'h10);

    // R8: power-down
    pwr = 1'b1; tick(3);
    start(0, 12'h7E7);
    len = 0;
    for (int k = 0; k < 30; k++) begin if (!busy) len++; tick(1); end
    chk("R8 no start in power-down", len, 0);
    read(hi, lo);
    chk("R8 result kept msb", hi, 8'h11);
    chk("R8 result kept lsb", lo, 8'h10);
    pwr = 1'b0; tick(3);

    // R6: enable gating
    par = 1'b0; cs_n = 1'b0; rc = 1'b1; tick(4);
    chk("R6 oe off in non-parallel", oe, 0);
    chk("R6 data zero in non-parallel", data, 0);
    par = 1'b1; tick(4);
    chk("R6 oe on with cs low rc high", oe, 1);
    chk("R6 data live", data, 8'h11);
    cs_n = 1'b1; tick(4);
    chk("R6 oe off with cs high", oe, 0);
    chk("R6 data zero with cs high", data, 0);

    // R7 live switching without a new read edge
    cs_n = 1'b0; tick(4);
    bsel = 1'b1; tick(3);
    chk("R7 live lsb", data, 8'h10);
    bsel = 1'b0; tick(3);
    chk("R7 live msb", data, 8'h11);
    cs_n = 1'b1; tick(3);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule